// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block holds the data of SMBus block transfers on the host side of a controller. It sits between the register front end and the transfer sequencer. The front end passes it accesses to the block data register, status-clear events and the byte count that software loads into the first data register. The sequencer passes it block write and block read requests, and it fills the storage with bytes received from the bus.

The block works in one of two modes. In buffer mode, software moves a whole message through a storage array: each access to the block data register reads or writes one slot and advances an index. In byte mode, software paces the transfer one byte at a time. Each time it clears the byte-done flag, the index moves to the next byte, and the last-byte control bit ends a read. The block keeps the busy, byte-done, interrupt and device-error flags that these sequences drive. It raises a one-cycle send request when a block write is ready to go onto the bus.

A `kill` input cancels the current operation. A `start` input begins a fresh command. Both return the index to slot 0. `kill` has the highest priority, then `start`, then the two sequencer requests. Front-end accesses that arrive in the same cycle as any of these are dropped.

Top module: `smbblk_xfer`

## Requirements
- R1: After reset, `index` is 0, `active` is low, and `busy`, `byte_done`, `intr`, `dev_err`, `send_pulse` and `cnt_load` are all 0.
- R2: In buffer mode, a block data write stores `wr_data` in the slot at `index` and advances `index` by one.
- R3: In buffer mode, `rd_data` shows the slot at `index`, and a read strobe advances `index`. If an operation is active and the advanced index equals `byte_count`, the operation ends: `active` low, `index` 0 and `busy` 0.
- R4: A block write request in buffer mode compares `index` with `byte_count`.
  - If they differ, it sets `dev_err`, sets `index` to 0 and raises no send.
  - If they are equal, it pulses `send_pulse`, sets `intr`, clears `busy` and sets `index` to 0.
- R5: A block write request in byte mode copies the held byte into slot 0 and sets `index` to 0. It also sets `busy`, `byte_done` and `active`.
- R6: In an active byte-mode write, clearing a set `byte_done` advances `index`.
  - If the new index equals `byte_count`, the block pulses `send_pulse`, sets `intr` and clears `busy` and `active`.
  - Otherwise it stores the held byte in the new slot and sets `byte_done` again. A block data write in the same cycle supplies the stored byte.
- R7: In an active byte-mode read, clearing a set `byte_done` advances `index` and presents that slot on `rd_data`.
  - With `last_byte` high, the operation ends with `intr` set, `busy` and `active` cleared and `index` 0.
  - Otherwise `byte_done` is set again.
- R8: The index wraps when it reaches the buffer size. In buffer mode an access made with `index` equal to DEPTH uses slot 0. In byte mode the advance from slot DEPTH-1 goes to slot 0.
- R9: A block read request sets `index` to 0 and sets `active`.
  - In buffer mode it pulses `cnt_load`, with `cnt_value` equal to `req_len`, and sets `intr`.
  - In byte mode it presents slot 0 on `rd_data` and sets `busy` and `byte_done`.
- R10: `kill` sets `index` to 0 and clears `active` and `busy`. `start` sets `index` to 0 and clears `active`. Priority runs kill, then start, then requests, then front-end accesses, and a lower event in the same cycle has no effect.
- R11: Clearing `byte_done` in buffer mode, or with no active operation, clears only that flag: `index` and `rd_data` are unchanged.
- R12: `clr_intr` clears `intr` and `clr_dev_err` clears `dev_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_mode | input | 1 | 1 selects buffer mode, 0 selects byte mode |
| last_byte | input | 1 | Control bit that ends a byte-mode read |
| byte_count | input | DW | Message length held in data register 0 |
| wr_en | input | 1 | Block data register write strobe |
| wr_data | input | DW | Block data register write value |
| rd_en | input | 1 | Block data register read strobe |
| rd_data | output | DW | Block data register read value |
| clr_byte_done | input | 1 | Software clears the byte-done flag |
| clr_intr | input | 1 | Software clears the interrupt flag |
| clr_dev_err | input | 1 | Software clears the device-error flag |
| start | input | 1 | A new command begins |
| kill | input | 1 | The current operation is cancelled |
| fill_en | input | 1 | Sequencer writes a received byte into storage |
| fill_addr | input | AW | Slot written by the sequencer |
| fill_data | input | DW | Byte written by the sequencer |
| req_write | input | 1 | Sequencer block write request |
| req_read | input | 1 | Sequencer block read request (storage already filled) |
| req_len | input | DW | Byte count returned by the bus for a read |
| send_pulse | output | 1 | One-cycle request to send the buffered block |
| cnt_load | output | 1 | One-cycle request to load `cnt_value` into data register 0 |
| cnt_value | output | DW | Byte count to load |
| busy | output | 1 | Host busy flag |
| byte_done | output | 1 | Byte-done flag |
| intr | output | 1 | Interrupt (transfer complete) flag |
| dev_err | output | 1 | Device error flag |
| active | output | 1 | An operation is in progress |
| index | output | IW | Current buffer index |

## Verification
The one pair of front-end events that may share a cycle is a byte-done clear and a block data write during a byte-mode write. The clear advances the index and captures a byte into the new slot, and the write updates the held byte. The bench raises both strobes at the same falling edge, using a new value each time, across message lengths 1 to 4. It then reads the storage back in buffer mode and expects each slot to hold the byte written in the cycle that filled it. A second collision, kill arriving together with a block write request, is judged by the absence of `send_pulse` and `intr`.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;

    typedef enum logic {
        XFER_WR = 1'b0,
        XFER_RD = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic busy;
        logic byte_done;
        logic intr;
        logic dev_err;
    } xfer_flags_t;

    localparam xfer_flags_t FLAGS_IDLE = '{busy: 1'b0, byte_done: 1'b0, intr: 1'b0, dev_err: 1'b0};

endpackage

// File: rtl/smbblk_store.sv
module smbblk_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_data,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_data
);

    logic [DW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign a_data = slot_q[a_addr];
    assign b_data = slot_q[b_addr];

endmodule

// File: rtl/smbblk_ctrl.sv
module smbblk_ctrl
    import smbblk_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          buf_mode,
    input  logic          last_byte,
    input  logic [DW-1:0] byte_count,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          clr_byte_done,
    input  logic          clr_intr,
    input  logic          clr_dev_err,
    input  logic          start,
    input  logic          kill,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic          req_write,
    input  logic          req_read,
    input  logic [DW-1:0] req_len,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] b_data,
    output logic [AW-1:0] a_addr,
    output logic [AW-1:0] b_addr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] rd_data,
    output logic [IW-1:0] index,
    output logic          active,
    output xfer_flags_t   flags,
    output logic          send_pulse,
    output logic          cnt_load,
    output logic [DW-1:0] cnt_value
);

    localparam logic [IW-1:0] DEPTH_I = IW'(DEPTH);
    localparam logic [IW-1:0] ONE_I   = IW'(1);

    logic [IW-1:0] idx_q, idx_n;
    logic          act_q, act_n;
    xfer_dir_e     dir_q, dir_n;
    logic [DW-1:0] hold_q, hold_n;
    xfer_flags_t   flg_q, flg_n;
    logic          send_q, send_n;
    logic          cld_q, cld_n;
    logic [DW-1:0] cval_q, cval_n;

    logic [IW-1:0] eff, eff_inc, step;
    logic          bd_advance;

    // Buffer mode wraps on use; byte mode wraps on advance.
    always_comb begin
        eff     = (idx_q >= DEPTH_I) ? '0 : idx_q;
        eff_inc = eff + ONE_I;
        step    = (eff_inc >= DEPTH_I) ? '0 : eff_inc;
    end

    assign a_addr     = eff[AW-1:0];
    assign b_addr     = req_read ? '0 : step[AW-1:0];
    assign bd_advance = clr_byte_done && flg_q.byte_done && act_q && !buf_mode;

    always_comb begin
        idx_n     = idx_q;
        act_n     = act_q;
        dir_n     = dir_q;
        hold_n    = hold_q;
        flg_n     = flg_q;
        send_n    = 1'b0;
        cld_n     = 1'b0;
        cval_n    = cval_q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;

        if (clr_byte_done) flg_n.byte_done = 1'b0;
        if (clr_intr)      flg_n.intr      = 1'b0;
        if (clr_dev_err)   flg_n.dev_err   = 1'b0;

        if (kill) begin
            idx_n      = '0;
            act_n      = 1'b0;
            flg_n.busy = 1'b0;
        end else if (start) begin
            idx_n = '0;
            act_n = 1'b0;
        end else if (req_write) begin
            dir_n = XFER_WR;
            idx_n = '0;
            if (buf_mode) begin
                if (DW'(idx_q) != byte_count) begin
                    flg_n.dev_err = 1'b1;
                end else begin
                    send_n     = 1'b1;
                    flg_n.intr = 1'b1;
                    flg_n.busy = 1'b0;
                    act_n      = 1'b0;
                end
            end else begin
                mem_we          = 1'b1;
                mem_waddr       = '0;
                mem_wdata       = hold_q;
                act_n           = 1'b1;
                flg_n.busy      = 1'b1;
                flg_n.byte_done = 1'b1;
            end
        end else if (req_read) begin
            dir_n = XFER_RD;
            idx_n = '0;
            act_n = 1'b1;
            if (buf_mode) begin
                cld_n      = 1'b1;
                cval_n     = req_len;
                flg_n.intr = 1'b1;
            end else begin
                hold_n          = b_data;
                flg_n.busy      = 1'b1;
                flg_n.byte_done = 1'b1;
            end
        end else begin
            if (fill_en) begin
                mem_we    = 1'b1;
                mem_waddr = fill_addr;
                mem_wdata = fill_data;
            end
            if (wr_en) begin
                if (buf_mode) begin
                    mem_we    = 1'b1;
                    mem_waddr = eff[AW-1:0];
                    mem_wdata = wr_data;
                    idx_n     = eff_inc;
                end else begin
                    hold_n = wr_data;
                end
            end
            if (rd_en && buf_mode) begin
                idx_n = eff_inc;
                if (act_q && DW'(eff_inc) == byte_count) begin
                    act_n      = 1'b0;
                    idx_n      = '0;
                    flg_n.busy = 1'b0;
                end
            end
            if (bd_advance) begin
                idx_n = step;
                if (dir_q == XFER_WR) begin
                    if (DW'(step) == byte_count) begin
                        send_n     = 1'b1;
                        flg_n.intr = 1'b1;
                        flg_n.busy = 1'b0;
                        act_n      = 1'b0;
                    end else begin
                        mem_we          = 1'b1;
                        mem_waddr       = step[AW-1:0];
                        mem_wdata       = wr_en ? wr_data : hold_q;
                        flg_n.byte_done = 1'b1;
                    end
                end else begin
                    hold_n = b_data;
                    if (last_byte) begin
                        idx_n      = '0;
                        act_n      = 1'b0;
                        flg_n.intr = 1'b1;
                        flg_n.busy = 1'b0;
                    end else begin
                        flg_n.byte_done = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            act_q  <= 1'b0;
            dir_q  <= XFER_WR;
            hold_q <= '0;
            flg_q  <= FLAGS_IDLE;
            send_q <= 1'b0;
            cld_q  <= 1'b0;
            cval_q <= '0;
        end else begin
            idx_q  <= idx_n;
            act_q  <= act_n;
            dir_q  <= dir_n;
            hold_q <= hold_n;
            flg_q  <= flg_n;
            send_q <= send_n;
            cld_q  <= cld_n;
            cval_q <= cval_n;
        end
    end

    assign rd_data    = buf_mode ? a_data : hold_q;
    assign index      = idx_q;
    assign active     = act_q;
    assign flags      = flg_q;
    assign send_pulse = send_q;
    assign cnt_load   = cld_q;
    assign cnt_value  = cval_q;

endmodule

// File: rtl/smbblk_xfer.sv
module smbblk_xfer
    import smbblk_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          buf_mode,
    input  logic          last_byte,
    input  logic [DW-1:0] byte_count,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          clr_byte_done,
    input  logic          clr_intr,
    input  logic          clr_dev_err,
    input  logic          start,
    input  logic          kill,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic          req_write,
    input  logic          req_read,
    input  logic [DW-1:0] req_len,
    output logic          send_pulse,
    output logic          cnt_load,
    output logic [DW-1:0] cnt_value,
    output logic          busy,
    output logic          byte_done,
    output logic          intr,
    output logic          dev_err,
    output logic          active,
    output logic [IW-1:0] index
);

    logic [AW-1:0] a_addr, b_addr, mem_waddr;
    logic [DW-1:0] a_data, b_data, mem_wdata;
    logic          mem_we;
    xfer_flags_t   flags;

    smbblk_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .a_addr (a_addr),
        .a_data (a_data),
        .b_addr (b_addr),
        .b_data (b_data)
    );

    smbblk_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .buf_mode      (buf_mode),
        .last_byte     (last_byte),
        .byte_count    (byte_count),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .clr_byte_done (clr_byte_done),
        .clr_intr      (clr_intr),
        .clr_dev_err   (clr_dev_err),
        .start         (start),
        .kill          (kill),
        .fill_en       (fill_en),
        .fill_addr     (fill_addr),
        .fill_data     (fill_data),
        .req_write     (req_write),
        .req_read      (req_read),
        .req_len       (req_len),
        .a_data        (a_data),
        .b_data        (b_data),
        .a_addr        (a_addr),
        .b_addr        (b_addr),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata),
        .rd_data       (rd_data),
        .index         (index),
        .active        (active),
        .flags         (flags),
        .send_pulse    (send_pulse),
        .cnt_load      (cnt_load),
        .cnt_value     (cnt_value)
    );

    assign busy      = flags.busy;
    assign byte_done = flags.byte_done;
    assign intr      = flags.intr;
    assign dev_err   = flags.dev_err;

endmodule

// File: rtl/smbblk_xfer_chk.sv
module smbblk_xfer_chk #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          buf_mode,
    input logic [DW-1:0] byte_count,
    input logic          rd_en,
    input logic          start,
    input logic          kill,
    input logic          req_write,
    input logic          req_read,
    input logic          send_pulse,
    input logic          cnt_load,
    input logic          busy,
    input logic          intr,
    input logic          dev_err,
    input logic          active,
    input logic [IW-1:0] index
);

    logic [IW-1:0] used_slot;
    logic          quiet;

    assign used_slot = (index >= IW'(DEPTH)) ? '0 : index;
    assign quiet     = !kill && !start && !req_write && !req_read;

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        index <= IW'(DEPTH)); // R8

    AST_KILL_IDLE: assert property (@(posedge clk) disable iff (rst)
        kill |=> (index == '0) && !active && !busy); // R10

    AST_SEND_DONE: assert property (@(posedge clk) disable iff (rst)
        send_pulse |-> intr && !busy && !active); // R4

    AST_ERR_NO_SEND: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_err) |-> !send_pulse); // R4

    AST_BUF_RD_END: assert property (@(posedge clk) disable iff (rst)
        (quiet && rd_en && buf_mode && active && (DW'(used_slot) + DW'(1) == byte_count))
        |=> !active && (index == '0) && !busy); // R3

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_load |-> intr && active && (index == '0)); // R9

endmodule

bind smbblk_xfer smbblk_xfer_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .buf_mode   (buf_mode),
    .byte_count (byte_count),
    .rd_en      (rd_en),
    .start      (start),
    .kill       (kill),
    .req_write  (req_write),
    .req_read   (req_read),
    .send_pulse (send_pulse),
    .cnt_load   (cnt_load),
    .busy       (busy),
    .intr       (intr),
    .dev_err    (dev_err),
    .active     (active),
    .index      (index)
);

// File: tb/smbblk_xfer_bench.sv
`timescale 1ns/1ps
module smbblk_xfer_bench;

    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int IW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          buf_mode = 1'b1, last_byte = 1'b0;
    logic [DW-1:0] byte_count = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          clr_byte_done = 1'b0, clr_intr = 1'b0, clr_dev_err = 1'b0;
    logic          start = 1'b0, kill = 1'b0;
    logic          fill_en = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          req_write = 1'b0, req_read = 1'b0;
    logic [DW-1:0] req_len = '0;
    logic          send_pulse, cnt_load, busy, byte_done, intr, dev_err, active;
    logic [DW-1:0] cnt_value;
    logic [IW-1:0] index;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smbblk_xfer #(.DEPTH(DEPTH), .DW(DW)) u_smbblk_xfer (
        .clk(clk), .rst(rst), .buf_mode(buf_mode), .last_byte(last_byte),
        .byte_count(byte_count), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .clr_byte_done(clr_byte_done),
        .clr_intr(clr_intr), .clr_dev_err(clr_dev_err), .start(start),
        .kill(kill), .fill_en(fill_en), .fill_addr(fill_addr),
        .fill_data(fill_data), .req_write(req_write), .req_read(req_read),
        .req_len(req_len), .send_pulse(send_pulse), .cnt_load(cnt_load),
        .cnt_value(cnt_value), .busy(busy), .byte_done(byte_done),
        .intr(intr), .dev_err(dev_err), .active(active), .index(index)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Inputs change at the falling edge; one rising edge is consumed.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; clr_byte_done = 0; clr_intr = 0; clr_dev_err = 0;
        start = 0; kill = 0; fill_en = 0; req_write = 0; req_read = 0;
    endtask

    function automatic logic [7:0] pat(input int a, input int b);
        return 8'((a * 37 + b * 11 + 5) & 8'hFF);
    endfunction

    task automatic do_start();
        start = 1; tick();
    endtask

    task automatic fill(input int addr, input logic [7:0] v);
        fill_en = 1; fill_addr = AW'(addr); fill_data = v; tick();
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 index", int'(index), 0);
        chk("R1 active", int'(active), 0);
        chk("R1 flags", int'({busy, byte_done, intr, dev_err}), 0);
        chk("R1 pulses", int'({send_pulse, cnt_load}), 0);

        // Buffer-mode write then read-back sweep
        buf_mode = 1;
        for (int n = 1; n <= DEPTH; n++) begin
            do_start();
            for (int k = 0; k < n; k++) begin
                wr_en = 1; wr_data = pat(n, k); tick();
                chk("R2 write index", int'(index), k + 1);
            end
            do_start();
            chk("R10 start index", int'(index), 0);
            for (int k = 0; k < n; k++) begin
                chk("R3 read data", int'(rd_data), int'(pat(n, k)));
                rd_en = 1; tick();
                chk("R3 read index", int'(index), k + 1);
            end
        end
        // index is now DEPTH: next write lands in slot 0
        wr_en = 1; wr_data = 8'hEE; tick();
        chk("R8 buffer wrap index", int'(index), 1);
        do_start();
        chk("R8 buffer wrap slot0", int'(rd_data), 8'hEE);

        // Buffer-mode block write request: match and mismatch
        for (int n = 1; n <= 4; n++) begin
            do_start();
            byte_count = 8'(n);
            for (int k = 0; k < n; k++) begin wr_en = 1; wr_data = pat(9, k); tick(); end
            req_write = 1; tick();
            chk("R4 send on match", int'(send_pulse), 1);
            chk("R4 intr/busy on match", int'({intr, busy, dev_err}), 3'b100);
            chk("R4 index after send", int'(index), 0);
            clr_intr = 1; tick();
            chk("R12 intr cleared", int'(intr), 0);
            chk("R4 send single pulse", int'(send_pulse), 0);
        end
        do_start();
        byte_count = 8'd4;
        for (int k = 0; k < 3; k++) begin wr_en = 1; wr_data = 8'(k); tick(); end
        req_write = 1; tick();
        chk("R4 mismatch error", int'(dev_err), 1);
        chk("R4 mismatch no send", int'({send_pulse, intr}), 0);
        chk("R4 mismatch index", int'(index), 0);
        clr_dev_err = 1; tick();
        chk("R12 dev_err cleared", int'(dev_err), 0);

        // Buffer-mode block read request
        for (int len = 1; len <= DEPTH; len++) begin
            for (int k = 0; k < len; k++) fill(k, pat(len, k + 3));
            req_read = 1; req_len = 8'(len); tick();
            chk("R9 cnt_load pulse", int'(cnt_load), 1);
            chk("R9 cnt_value", int'(cnt_value), len);
            chk("R9 intr/active", int'({intr, active}), 2'b11);
            byte_count = cnt_value;
            for (int k = 0; k < len; k++) begin
                chk("R3 op read data", int'(rd_data), int'(pat(len, k + 3)));
                rd_en = 1; tick();
                chk("R3 op index", int'(index), (k + 1 == len) ? 0 : k + 1);
                chk("R3 op active", int'(active), (k + 1 == len) ? 0 : 1);
            end
            clr_intr = 1; tick();
        end

        // Byte-mode write with same-cycle clear and data write
        for (int n = 1; n <= 4; n++) begin
            buf_mode = 0;
            byte_count = 8'(n);
            wr_en = 1; wr_data = pat(n, 40); tick();
            req_write = 1; tick();
            chk("R5 busy/byte_done/active", int'({busy, byte_done, active}), 3'b111);
            chk("R5 index", int'(index), 0);
            for (int k = 1; k <= n; k++) begin
                clr_byte_done = 1; wr_en = 1; wr_data = pat(n, 40 + k); tick();
                if (k < n) begin
                    chk("R6 index advance", int'(index), k);
                    chk("R6 byte_done again", int'({byte_done, send_pulse}), 2'b10);
                end else begin
                    chk("R6 send at count", int'(send_pulse), 1);
                    chk("R6 finish flags", int'({intr, busy, active}), 3'b100);
                end
            end
            clr_intr = 1; tick();
            buf_mode = 1;
            do_start();
            for (int k = 0; k < n; k++) begin
                chk("R6 stored byte", int'(rd_data), int'(pat(n, 40 + k)));
                rd_en = 1; tick();
            end
        end

        // Byte-mode read: paced bytes then last-byte finish
        for (int m = 1; m <= 5; m++) begin
            buf_mode = 1;
            for (int k = 0; k <= m; k++) fill(k, pat(m, 60 + k));
            buf_mode = 0; last_byte = 0;
            req_read = 1; tick();
            chk("R9 byte read first", int'(rd_data), int'(pat(m, 60)));
            chk("R9 byte read flags", int'({busy, byte_done, active}), 3'b111);
            for (int k = 1; k < m; k++) begin
                clr_byte_done = 1; tick();
                chk("R7 next byte", int'(rd_data), int'(pat(m, 60 + k)));
                chk("R7 byte_done again", int'(byte_done), 1);
                chk("R7 index", int'(index), k);
            end
            last_byte = 1; clr_byte_done = 1; tick();
            last_byte = 0;
            chk("R7 last byte data", int'(rd_data), int'(pat(m, 60 + m)));
            chk("R7 last finish flags", int'({intr, busy, active, byte_done}), 4'b1000);
            chk("R7 last index", int'(index), 0);
            clr_intr = 1; tick();
        end

        // Byte-mode index wrap
        buf_mode = 1;
        for (int k = 0; k < DEPTH; k++) fill(k, pat(7, 80 + k));
        buf_mode = 0;
        req_read = 1; tick();
        for (int k = 1; k <= DEPTH; k++) begin
            clr_byte_done = 1; tick();
        end
        chk("R8 byte wrap index", int'(index), 0);
        chk("R8 byte wrap data", int'(rd_data), int'(pat(7, 80)));
        kill = 1; tick();

        // Kill mid-write, then a stray byte-done clear
        buf_mode = 0; byte_count = 8'd5;
        wr_en = 1; wr_data = 8'h5A; tick();
        req_write = 1; tick();
        clr_byte_done = 1; tick();
        chk("R6 index before kill", int'(index), 1);
        kill = 1; tick();
        chk("R10 kill index", int'(index), 0);
        chk("R10 kill idle", int'({active, busy}), 0);
        chk("R10 byte_done kept", int'(byte_done), 1);
        clr_byte_done = 1; tick();
        chk("R11 flag cleared", int'(byte_done), 0);
        chk("R11 index unchanged", int'(index), 0);
        chk("R11 no send", int'(send_pulse), 0);
        chk("R11 held byte", int'(rd_data), 8'h5A);

        // Buffer-mode clear of byte_done has no effect on index
        buf_mode = 1;
        do_start();
        wr_en = 1; wr_data = 8'h11; tick();
        clr_byte_done = 1; tick();
        chk("R11 buffer mode index", int'(index), 1);

        // Kill beats a same-cycle write request
        do_start();
        byte_count = 8'd2;
        wr_en = 1; wr_data = 8'h21; tick();
        wr_en = 1; wr_data = 8'h22; tick();
        kill = 1; req_write = 1; tick();
        chk("R10 kill priority send", int'({send_pulse, intr}), 0);
        chk("R10 kill priority index", int'(index), 0);

        // Start beats a same-cycle data write
        wr_en = 1; wr_data = 8'h33; tick();
        start = 1; wr_en = 1; wr_data = 8'h44; tick();
        chk("R10 start priority index", int'(index), 0);
        chk("R10 start priority data", int'(rd_data), 8'h33);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule